// File: doc/BRIEF.md
# Legacy Parallel Port Register Block

This block gives a host a byte-wide register view of a PC-style parallel port. A small synchronous bus with a 2-bit select reaches three registers: one for the data lines, one for the port status pins and one for the control pins. On the port side the block drives the eight data lines with an output enable, reads the five status pins, drives the four control pins and raises an interrupt line.

Every register bit follows a fixed polarity rule toward its pin, and the block applies those inversions so that software sees a consistent view. The status pins pass through a two-flop synchronizer before they are read or checked for edges. A direction bit in the control register, together with an extended-mode input, decides whether the data-line drivers are on. When the interrupt-enable control bit is set, a rising edge on the acknowledge pin gives a one-cycle interrupt pulse.

Top module: `pport_regs`

## Requirements
- R1: A status read (select 1) returns bit 7 = inverted busy_i, bit 6 = nack_i, bit 5 = perror_i, bit 4 = select_i, bit 3 = nfault_i, bits 2..0 = 0. The value reflects pin levels held for three clock edges.
- R2: A write with select 1 changes no register: status, control and data read-back and all port outputs stay as they were.
- R3: Control bit 0 drives nstrobe_o inverted, bit 1 drives nautofd_o inverted, bit 3 drives nselectin_o inverted, and bit 2 drives ninit_o uninverted. Each pin takes its value one edge after the write (select 2).
- R4: A control read (select 2) returns the six stored control bits in bits 5..0, with bits 7..6 read as 0 whatever was written.
- R5: A data write (select 0) sets pd_out one edge after the write.
- R6: pd_oe is low exactly when ext_mode is high and control bit 5 (direction) is set. Otherwise it is high.
- R7: A data read (select 0) returns the level of pd_in at the capturing edge, not the written data register.
- R8: With control bit 4 set, each rising edge of nack_i gives irq_o high for exactly one cycle, on the third edge after the pin rises. No pulse occurs on a falling edge or while bit 4 is clear.
- R9: After reset the control and data registers are 0x00. So pd_out = 0x00, pd_oe = 1, nstrobe_o = 1, nautofd_o = 1, nselectin_o = 1, ninit_o = 0, irq_o = 0 and bus_rdata = 0x00.
- R10: Select 3 reads as 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 2 | Register select: 0 data, 1 status, 2 control, 3 unused |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the select at the last edge |
| ext_mode | input | 1 | High when the port runs in an extended mode |
| pd_in | input | 8 | Levels seen on the data lines |
| pd_out | output | 8 | Data driven onto the data lines |
| pd_oe | output | 1 | Data-line driver enable |
| busy_i | input | 1 | Busy pin |
| nack_i | input | 1 | Acknowledge pin, active low |
| perror_i | input | 1 | Paper-error pin |
| select_i | input | 1 | Select pin |
| nfault_i | input | 1 | Fault pin, active low |
| nstrobe_o | output | 1 | Strobe pin, active low |
| nautofd_o | output | 1 | Auto-feed pin, active low |
| ninit_o | output | 1 | Init pin, active low |
| nselectin_o | output | 1 | Select-in pin, active low |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
Results fall due at different times. Control pins, pd_out and pd_oe change one edge after a write, and data and control reads are valid one edge after the select is set. Status reads need three edges from a pin change, and the interrupt pulse appears on the third edge after the acknowledge rise. The bench changes inputs on the falling clock edge and waits the right number of rising edges for each result. It then samples at the next falling edge. For the interrupt it looks at each of six cycles, so a pulse that is early, late or doubled is caught.

// File: rtl/pport_pkg.sv
// Shared constants and types for the parallel port register block.
// Assumes an 8-bit register width; the status layout is fixed by the port.
package pport_pkg;
    localparam int REG_W = 8;
    localparam int SEL_W = 2;
    localparam int STS_W = 5;   // busy, nack, perror, select, nfault
    localparam int CTL_W = 6;   // stored control bits

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA   = 2'd0,
        SEL_STATUS = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Control bit positions
    localparam int CB_STROBE = 0;
    localparam int CB_AFEED  = 1;
    localparam int CB_INIT   = 2;
    localparam int CB_SELIN  = 3;
    localparam int CB_IRQEN  = 4;
    localparam int CB_DIR    = 5;

    // Status vector positions inside the synchronizer bus
    localparam int SV_NFAULT = 0;
    localparam int SV_SELECT = 1;
    localparam int SV_PERROR = 2;
    localparam int SV_NACK   = 3;
    localparam int SV_BUSY   = 4;
endpackage

// File: rtl/pport_sync.sv
// Multi-flop synchronizer for asynchronous pin inputs.
// Assumes each bit is independent (no bus coherency needed); resets to 0.
module pport_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the inputs through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pport_edge.sv
// Rising-edge pulse generator with enable.
// Assumes sig_i is already synchronous; the pulse is registered and one cycle wide.
module pport_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic en_i,
    output logic pulse_o
);
    logic sig_d;

    // Keep the last value and register the gated rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_d   <= 1'b0;
            pulse_o <= 1'b0;
        end else begin
            sig_d   <= sig_i;
            pulse_o <= en_i & sig_i & ~sig_d;
        end
    end
endmodule

// File: rtl/pport_rdmux.sv
// Read-data selection for the register block.
// Assumes synchronized status inputs; reserved bits and the unused select read zero.
module pport_rdmux
    import pport_pkg::*;
(
    input  logic [SEL_W-1:0] sel_i,
    input  logic [REG_W-1:0] lines_i,
    input  logic [STS_W-1:0] sts_i,
    input  logic [CTL_W-1:0] ctl_i,
    output logic [REG_W-1:0] rdata_o
);
    logic [REG_W-1:0] sts_word;
    logic [REG_W-1:0] ctl_word;

    // Assemble the status word with the busy inversion
    always_comb begin
        sts_word    = '0;
        sts_word[7] = ~sts_i[SV_BUSY];
        sts_word[6] = sts_i[SV_NACK];
        sts_word[5] = sts_i[SV_PERROR];
        sts_word[4] = sts_i[SV_SELECT];
        sts_word[3] = sts_i[SV_NFAULT];
    end

    // Zero-extend the stored control bits
    always_comb begin
        ctl_word = '0;
        ctl_word[CTL_W-1:0] = ctl_i;
    end

    // Pick the word for the current select
    always_comb begin
        unique case (reg_sel_e'(sel_i))
            SEL_DATA:   rdata_o = lines_i;
            SEL_STATUS: rdata_o = sts_word;
            SEL_CTRL:   rdata_o = ctl_word;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/pport_regs.sv
// Parallel port host register block: data, status and control registers.
// Applies pin polarities, drives the data-line enable from mode and direction,
// and pulses an interrupt on a synchronized acknowledge rising edge.
// Assumes the host bus is synchronous to clk; status pins are asynchronous.
module pport_regs
    import pport_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] bus_sel,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             ext_mode,
    input  logic [REG_W-1:0] pd_in,
    output logic [REG_W-1:0] pd_out,
    output logic             pd_oe,
    input  logic             busy_i,
    input  logic             nack_i,
    input  logic             perror_i,
    input  logic             select_i,
    input  logic             nfault_i,
    output logic             nstrobe_o,
    output logic             nautofd_o,
    output logic             ninit_o,
    output logic             nselectin_o,
    output logic             irq_o
);
    logic [CTL_W-1:0] ctl_q;
    logic [REG_W-1:0] data_q;
    logic [STS_W-1:0] sts_raw;
    logic [STS_W-1:0] sts_sync;
    logic [REG_W-1:0] rd_word;

    assign sts_raw[SV_BUSY]   = busy_i;
    assign sts_raw[SV_NACK]   = nack_i;
    assign sts_raw[SV_PERROR] = perror_i;
    assign sts_raw[SV_SELECT] = select_i;
    assign sts_raw[SV_NFAULT] = nfault_i;

    pport_sync #(.WIDTH(STS_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sts_raw),
        .q_o   (sts_sync)
    );

    pport_edge edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_i   (sts_sync[SV_NACK]),
        .en_i    (ctl_q[CB_IRQEN]),
        .pulse_o (irq_o)
    );

    pport_rdmux rdmux_i (
        .sel_i   (bus_sel),
        .lines_i (pd_in),
        .sts_i   (sts_sync),
        .ctl_i   (ctl_q),
        .rdata_o (rd_word)
    );

    // Register host writes to the data and control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            ctl_q  <= '0;
        end else if (bus_wr) begin
            if (reg_sel_e'(bus_sel) == SEL_DATA) data_q <= bus_wdata;
            if (reg_sel_e'(bus_sel) == SEL_CTRL) ctl_q  <= bus_wdata[CTL_W-1:0];
        end
    end

    // Register the read data for the current select
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_word;
    end

    // Pin polarity and data-line direction
    assign pd_out      = data_q;
    assign pd_oe       = ~(ext_mode & ctl_q[CB_DIR]);
    assign nstrobe_o   = ~ctl_q[CB_STROBE];
    assign nautofd_o   = ~ctl_q[CB_AFEED];
    assign ninit_o     =  ctl_q[CB_INIT];
    assign nselectin_o = ~ctl_q[CB_SELIN];
endmodule

// File: rtl/pport_regs_chk.sv
// Checker for pport_regs, attached by bind. Watches port behaviour over time.
module pport_regs_chk
    import pport_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] bus_sel,
    input logic             bus_wr,
    input logic [REG_W-1:0] bus_wdata,
    input logic [REG_W-1:0] pd_out,
    input logic             pd_oe,
    input logic             ext_mode,
    input logic             nstrobe_o,
    input logic             nautofd_o,
    input logic             ninit_o,
    input logic             nselectin_o,
    input logic             irq_o
);
    p_ctl_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == SEL_CTRL) |=>
            (nstrobe_o == !$past(bus_wdata[0]) && nautofd_o == !$past(bus_wdata[1]) &&
             ninit_o == $past(bus_wdata[2]) && nselectin_o == !$past(bus_wdata[3])));

    p_data_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == SEL_DATA) |=> (pd_out == $past(bus_wdata)));

    p_compat_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> pd_oe);

    p_sts_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == SEL_STATUS) |=>
            ($stable(pd_out) && $stable(nstrobe_o) && $stable(ninit_o) &&
             $stable(nautofd_o) && $stable(nselectin_o)));

    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
endmodule

bind pport_regs pport_regs_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .pd_out      (pd_out),
    .pd_oe       (pd_oe),
    .ext_mode    (ext_mode),
    .nstrobe_o   (nstrobe_o),
    .nautofd_o   (nautofd_o),
    .ninit_o     (ninit_o),
    .nselectin_o (nselectin_o),
    .irq_o       (irq_o)
);

// File: tb/pport_regs_tb_top.sv
module pport_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_mode = 1'b0;
    logic [7:0] pd_in = 8'd0;
    logic [7:0] pd_out;
    logic       pd_oe;
    logic       busy_i = 1'b0, nack_i = 1'b0, perror_i = 1'b0, select_i = 1'b0, nfault_i = 1'b0;
    logic       nstrobe_o, nautofd_o, ninit_o, nselectin_o, irq_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] ctl_model = 8'd0;
    logic [7:0] data_model = 8'd0;

    always #10 clk = ~clk;

    pport_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_mode(ext_mode),
        .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe), .busy_i(busy_i),
        .nack_i(nack_i), .perror_i(perror_i), .select_i(select_i),
        .nfault_i(nfault_i), .nstrobe_o(nstrobe_o), .nautofd_o(nautofd_o),
        .ninit_o(ninit_o), .nselectin_o(nselectin_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] exp_status(logic b, logic a, logic p, logic s, logic f);
        return {~b, a, p, s, f, 3'b000};
    endfunction

    function automatic logic [3:0] exp_pins(logic [7:0] c);
        // {nselectin, ninit, nautofd, nstrobe}
        return {~c[3], c[2], ~c[1], ~c[0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] sel, logic [7:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (sel == 2'd0) data_model = d;
        if (sel == 2'd2) ctl_model = {2'b00, d[5:0]};
    endtask

    task automatic bus_read(logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        bus_sel = sel;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic check_ctl_outputs(string req);
        check(req, {nselectin_o, ninit_o, nautofd_o, nstrobe_o}, exp_pins(ctl_model));
        check(req, pd_oe, !(ext_mode && ctl_model[5]));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [7:0] rd;
        logic [7:0] v;
        logic [4:0] st;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9 pd_out", pd_out, 8'h00);
        check("R9 pd_oe", pd_oe, 1'b1);
        check("R9 pins", {nselectin_o, ninit_o, nautofd_o, nstrobe_o}, 4'b1011);
        check("R9 irq", irq_o, 1'b0);
        check("R9 rdata", bus_rdata, 8'h00);
        bus_read(2'd2, rd);
        check("R9 ctl", rd, 8'h00);

        // R3 R4 R6 random control writes
        for (int i = 0; i < 40; i++) begin
            v = 8'($urandom());
            v[4] = 1'b0;
            ext_mode = 1'($urandom());
            bus_write(2'd2, v);
            check_ctl_outputs("R3/R6 ctl pins");
            bus_read(2'd2, rd);
            check("R4 ctl readback", rd, ctl_model);
        end
        // R6 directed corners
        bus_write(2'd2, 8'h20);
        ext_mode = 1'b1; #1;
        check("R6 ext+dir", pd_oe, 1'b0);
        ext_mode = 1'b0; #1;
        check("R6 compat+dir", pd_oe, 1'b1);

        // R5 R7 data path
        for (int i = 0; i < 20; i++) begin
            v = 8'($urandom());
            bus_write(2'd0, v);
            check("R5 pd_out", pd_out, v);
            pd_in = 8'($urandom());
            bus_read(2'd0, rd);
            check("R7 data read", rd, pd_in);
        end

        // R1 status random
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            st = 5'($urandom());
            {busy_i, nack_i, perror_i, select_i, nfault_i} = st;
            bus_sel = 2'd1;
            repeat (3) @(posedge clk);
            @(negedge clk);
            check("R1 status", bus_rdata, exp_status(st[4], st[3], st[2], st[1], st[0]));
        end

        // R2 status write ignored
        v = pd_out;
        bus_write(2'd1, 8'hFF);
        check("R2 pd_out", pd_out, v);
        check_ctl_outputs("R2 ctl pins");
        bus_read(2'd1, rd);
        check("R2 status", rd, exp_status(busy_i, nack_i, perror_i, select_i, nfault_i));
        bus_read(2'd2, rd);
        check("R2 ctl", rd, ctl_model);

        // R10 unused select
        bus_write(2'd3, 8'hA5);
        bus_read(2'd3, rd);
        check("R10 read zero", rd, 8'h00);
        bus_read(2'd2, rd);
        check("R10 ctl kept", rd, ctl_model);
        check("R10 pd_out kept", pd_out, data_model);

        // R8 interrupt: enabled rising, falling, disabled
        bus_write(2'd2, 8'h10);
        for (int pass = 0; pass < 3; pass++) begin
            @(negedge clk);
            nack_i = (pass == 1) ? 1'b1 : 1'b0;
            repeat (5) @(negedge clk);
            if (pass == 2) bus_write(2'd2, 8'h00);
            @(negedge clk);
            nack_i = (pass == 1) ? 1'b0 : 1'b1;
            for (int k = 1; k <= 6; k++) begin
                @(negedge clk);
                check($sformatf("R8 pass%0d cycle%0d", pass, k), irq_o,
                      (pass == 0 && k == 3) ? 1'b1 : 1'b0);
            end
        end
        // R8 repeated edges each pulse
        bus_write(2'd2, 8'h10);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); nack_i = 1'b0;
            repeat (4) @(negedge clk);
            nack_i = 1'b1;
            repeat (2) @(negedge clk);
            @(negedge clk);
            check("R8 repeat pulse", irq_o, 1'b1);
            @(negedge clk);
            check("R8 pulse width", irq_o, 1'b0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule